// File: doc/BRIEF.md
# Four-Channel PWM Generator

This block drives four pulse-width-modulated outputs from one peripheral clock. Software programs it through a plain word-addressed write/read port. Each channel first slows the clock by a prescaler value. The two channels of a pair share that prescaler. Each channel then applies its own power-of-two selector and runs a 16-bit down-counter that reloads from a period register. The output is high while the counter is at or below a compare register. The ratio of compare to period therefore sets the duty.

Each channel has a small control field with three bits: an enable, a mode bit that picks between free-running (auto-reload) and single-period operation, and an invert bit. Period and compare values go into shadow copies when the channel is enabled, and again at every period end. Software can therefore retune a running channel without producing a malformed cycle.

Top module: `pwm_quad`

## Requirements
- R1: After reset every output is low and every register word reads 0.
- R2: Register map (word addresses). Word 0 holds the shared prescalers: bits [7:0] for channels 0/1 and [15:8] for channels 2/3. Word 1 holds the 3-bit selector of channel c at bit 4c. Word 2 holds the 4-bit control field of channels 0..3 at bits 0, 8, 12 and 16, where field bit 0 is enable, bit 2 is invert and bit 3 is auto-reload (bit 1 is stored only). Words 4+c and 8+c hold the 16-bit period and compare of channel c. Every field reads back as written, and all other bits read 0.
- R3: The counter steps once every (PRE+1)×D clock cycles. D is 2, 4, 8, 16 or 1 for selector codes 0, 1, 2, 3 and 4, and codes 5–7 act as 1. One output period lasts (PERIOD+1)×(PRE+1)×D cycles. While the configuration is unchanged, the output changes only after a counter step.
- R4: Channels 0 and 1 take their prescaler from word 0 bits [7:0], and channels 2 and 3 take theirs from bits [15:8].
- R5: In auto-reload mode with 0 < COMPARE < PERIOD, the output is high for (COMPARE+1)×(PRE+1)×D cycles of each period.
- R6: With COMPARE ≥ PERIOD (PERIOD ≠ 0), the output stays high.
- R7: With PERIOD = 0 an enabled channel is stopped: the output is low, or high when inverted.
- R8: The invert bit makes the high time equal to the period minus the non-inverted high time.
- R9: A disabled channel drives low and ignores its invert and mode bits.
- R10: In single-period mode, enabling gives exactly one high pulse of the R5 length, and the output then stays low. Clearing and setting enable again re-arms it.
- R11: Period and compare writes take effect at the next period end (or on enable). A write during a period does not alter that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 4 | Word address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 4 | Channel outputs, bit c is channel c |

## Verification
The bench measures high time and rising edges over windows that span a whole number of periods. A wrong divisor or a prescaler taken from the other pair's byte therefore shows up as a wrong count, not a phase shift. Compare at or above period must give a flat high line, and a period of zero must give a flat line that follows the invert bit. An off-by-one compare would leave a one-tick notch or a one-tick spike. The single-period mode is checked for exactly one pulse, silence afterwards and a clean re-arm. A compare write made just after enabling must not change the pulse that is already under way. A design that bypassed the shadow copies would stretch that pulse.

// File: rtl/pwm_quad_pkg.sv
// Package: shared sizes, register word addresses, field offsets and masks
// for the four-channel PWM generator. Field offsets are computed here so
// the register file and the checker agree on one definition.
package pwm_quad_pkg;

    localparam int unsigned CH_NUM    = 4;
    localparam int unsigned PAIR_NUM  = CH_NUM / 2;
    localparam int unsigned CNT_W     = 16;
    localparam int unsigned PRE_W     = 8;
    localparam int unsigned SEL_W     = 3;
    localparam int unsigned CTL_W     = 4;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned ADDR_W    = 4;
    localparam int unsigned SEL_CODES = 4;          // codes below this divide by 2^(code+1)
    localparam int unsigned SHIFT_W   = 3;
    localparam int unsigned DIV_W     = PRE_W + SEL_CODES + 1;

    // word addresses
    localparam int unsigned ADDR_PRE      = 0;
    localparam int unsigned ADDR_SEL      = 1;
    localparam int unsigned ADDR_CTL      = 2;
    localparam int unsigned ADDR_PRD_BASE = 4;
    localparam int unsigned ADDR_CMP_BASE = 8;

    // bit positions inside one control field
    localparam int unsigned CTL_EN    = 0;
    localparam int unsigned CTL_SPARE = 1;
    localparam int unsigned CTL_INV   = 2;
    localparam int unsigned CTL_TOG   = 3;

    // lsb of the prescaler byte for a channel pair
    function automatic int unsigned pre_lsb(input int unsigned pair);
        return pair * PRE_W;
    endfunction

    // lsb of the selector field of a channel
    function automatic int unsigned sel_lsb(input int unsigned ch);
        return ch * 4;
    endfunction

    // lsb of the control field of a channel: 0, 8, 12, 16
    function automatic int unsigned ctl_lsb(input int unsigned ch);
        return (ch == 0) ? 0 : (4 * ch + 4);
    endfunction

    // all bits of the control word that hold a field
    function automatic logic [DATA_W-1:0] ctl_mask_f();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int c = 0; c < CH_NUM; c++) begin
            m[ctl_lsb(c) +: CTL_W] = '1;
        end
        return m;
    endfunction

    // all bits of the prescaler word that hold a field
    function automatic logic [DATA_W-1:0] pre_mask_f();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int p = 0; p < PAIR_NUM; p++) begin
            m[pre_lsb(p) +: PRE_W] = '1;
        end
        return m;
    endfunction

    localparam logic [DATA_W-1:0] CTL_MASK = ctl_mask_f();
    localparam logic [DATA_W-1:0] PRE_MASK = pre_mask_f();

endpackage

// File: rtl/pwm_quad_regs.sv
// Register file: holds the shared prescalers, per-channel selectors,
// control fields, periods and compares, and returns the addressed word.
// Assumes one write per cycle; reads are combinational from stored state.
module pwm_quad_regs
    import pwm_quad_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             bus_we,
    input  logic [ADDR_W-1:0]                bus_addr,
    input  logic [DATA_W-1:0]                bus_wdata,
    output logic [DATA_W-1:0]                bus_rdata,
    output logic [CH_NUM-1:0][PRE_W-1:0]     ch_pre,
    output logic [CH_NUM-1:0][SEL_W-1:0]     ch_sel,
    output logic [CH_NUM-1:0][CTL_W-1:0]     ch_ctl,
    output logic [CH_NUM-1:0][CNT_W-1:0]     ch_prd,
    output logic [CH_NUM-1:0][CNT_W-1:0]     ch_cmp
);

    logic [PAIR_NUM-1:0][PRE_W-1:0] pre_q;
    logic                           wr_pre;
    logic                           wr_sel;
    logic                           wr_ctl;
    logic                           unused_wdata;

    assign wr_pre = bus_we && (bus_addr == ADDR_W'(ADDR_PRE));
    assign wr_sel = bus_we && (bus_addr == ADDR_W'(ADDR_SEL));
    assign wr_ctl = bus_we && (bus_addr == ADDR_W'(ADDR_CTL));
    assign unused_wdata = ^bus_wdata;

    // Store both shared prescaler bytes on a write to the prescaler word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (wr_pre) begin
            for (int p = 0; p < PAIR_NUM; p++) begin
                pre_q[p] <= bus_wdata[pre_lsb(p) +: PRE_W];
            end
        end
    end

    for (genvar c = 0; c < CH_NUM; c++) begin : g_ch
        localparam int unsigned SL = sel_lsb(c);
        localparam int unsigned CL = ctl_lsb(c);
        logic [SEL_W-1:0] sel_r;
        logic [CTL_W-1:0] ctl_r;
        logic [CNT_W-1:0] prd_r;
        logic [CNT_W-1:0] cmp_r;
        logic             wr_prd;
        logic             wr_cmp;

        assign wr_prd = bus_we && (bus_addr == ADDR_W'(ADDR_PRD_BASE + c));
        assign wr_cmp = bus_we && (bus_addr == ADDR_W'(ADDR_CMP_BASE + c));

        // Capture this channel's selector and control fields from shared words.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_r <= '0;
                ctl_r <= '0;
            end else begin
                if (wr_sel) sel_r <= bus_wdata[SL +: SEL_W];
                if (wr_ctl) ctl_r <= bus_wdata[CL +: CTL_W];
            end
        end

        // Capture this channel's period and compare words.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prd_r <= '0;
                cmp_r <= '0;
            end else begin
                if (wr_prd) prd_r <= bus_wdata[CNT_W-1:0];
                if (wr_cmp) cmp_r <= bus_wdata[CNT_W-1:0];
            end
        end

        assign ch_pre[c] = pre_q[c / 2];
        assign ch_sel[c] = sel_r;
        assign ch_ctl[c] = ctl_r;
        assign ch_prd[c] = prd_r;
        assign ch_cmp[c] = cmp_r;
    end

    // Assemble the addressed word; unassigned bits and addresses read zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(ADDR_PRE)) begin
            for (int p = 0; p < PAIR_NUM; p++) begin
                bus_rdata[pre_lsb(p) +: PRE_W] = pre_q[p];
            end
        end
        if (bus_addr == ADDR_W'(ADDR_SEL)) begin
            for (int c = 0; c < CH_NUM; c++) begin
                bus_rdata[sel_lsb(c) +: SEL_W] = ch_sel[c];
            end
        end
        if (bus_addr == ADDR_W'(ADDR_CTL)) begin
            for (int c = 0; c < CH_NUM; c++) begin
                bus_rdata[ctl_lsb(c) +: CTL_W] = ch_ctl[c];
            end
        end
        for (int c = 0; c < CH_NUM; c++) begin
            if (bus_addr == ADDR_W'(ADDR_PRD_BASE + c)) bus_rdata[CNT_W-1:0] = ch_prd[c];
            if (bus_addr == ADDR_W'(ADDR_CMP_BASE + c)) bus_rdata[CNT_W-1:0] = ch_cmp[c];
        end
    end

endmodule

// File: rtl/pwm_quad_div.sv
// Tick divider: one pulse every (pre+1) * 2^(sel+1) cycles, or every
// (pre+1) cycles for selector codes SEL_CODES and above. The counter
// is held at zero while run is low, so the first tick after start lands
// a full interval later.
module pwm_quad_div
    import pwm_quad_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] pre,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    logic [SHIFT_W-1:0] shift;
    logic [DIV_W-1:0]   lim;
    logic [DIV_W-1:0]   cnt;

    // Map the selector code to a shift amount.
    always_comb begin
        if (sel < SEL_W'(SEL_CODES)) begin
            shift = SHIFT_W'(sel) + SHIFT_W'(1);
        end else begin
            shift = '0;
        end
    end

    assign lim  = ((DIV_W'(pre) + DIV_W'(1)) << shift) - DIV_W'(1);
    assign tick = run && (cnt >= lim);

    // Count cycles up to the limit, then wrap with a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

endmodule

// File: rtl/pwm_quad_chan.sv
// One PWM channel: a down-counter over shadow copies of period and compare,
// loaded on enable and at each period end. The output is high while the
// count is at or below the shadow compare, and is then optionally inverted.
// Single-period mode stops after one period until enable is re-applied.
// Assumes the tick input comes from a divider run by this channel's run output.
module pwm_quad_chan
    import pwm_quad_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CTL_W-1:0] ctl,
    input  logic [CNT_W-1:0] prd_reg,
    input  logic [CNT_W-1:0] cmp_reg,
    input  logic             tick,
    output logic             run,
    output logic             pwm
);

    logic             en;
    logic             inv;
    logic             tog;
    logic             en_q;
    logic             done;
    logic             level;
    logic             unused_spare;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] prd_sh;
    logic [CNT_W-1:0] cmp_sh;

    assign en           = ctl[CTL_EN];
    assign inv          = ctl[CTL_INV];
    assign tog          = ctl[CTL_TOG];
    assign unused_spare = ctl[CTL_SPARE];
    assign run          = en_q;

    // Load on enable, step on tick, reload shadows at each period end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            done   <= 1'b0;
            cnt    <= '0;
            prd_sh <= '0;
            cmp_sh <= '0;
        end else begin
            en_q <= en;
            if (en && !en_q) begin
                cnt    <= prd_reg;
                prd_sh <= prd_reg;
                cmp_sh <= cmp_reg;
                done   <= 1'b0;
            end else if (en && en_q && tick) begin
                if (cnt == '0) begin
                    cnt    <= prd_reg;
                    prd_sh <= prd_reg;
                    cmp_sh <= cmp_reg;
                    if (!tog) done <= 1'b1;
                end else begin
                    cnt <= cnt - CNT_W'(1);
                end
            end
        end
    end

    assign level = en && en_q && (tog || !done) && (prd_sh != '0) && (cnt <= cmp_sh);
    assign pwm   = (en && en_q) ? (level ^ inv) : 1'b0;

endmodule

// File: rtl/pwm_quad.sv
// Top of the four-channel PWM generator: register file plus one tick
// divider and one counting channel per output.
module pwm_quad
    import pwm_quad_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [CH_NUM-1:0] pwm_out
);

    logic [CH_NUM-1:0][PRE_W-1:0] ch_pre;
    logic [CH_NUM-1:0][SEL_W-1:0] ch_sel;
    logic [CH_NUM-1:0][CTL_W-1:0] ch_ctl;
    logic [CH_NUM-1:0][CNT_W-1:0] ch_prd;
    logic [CH_NUM-1:0][CNT_W-1:0] ch_cmp;
    logic [CH_NUM-1:0]            ch_tick;
    logic [CH_NUM-1:0]            ch_run;

    pwm_quad_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ch_pre    (ch_pre),
        .ch_sel    (ch_sel),
        .ch_ctl    (ch_ctl),
        .ch_prd    (ch_prd),
        .ch_cmp    (ch_cmp)
    );

    for (genvar c = 0; c < CH_NUM; c++) begin : g_ch
        pwm_quad_div u_div (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (ch_run[c]),
            .pre   (ch_pre[c]),
            .sel   (ch_sel[c]),
            .tick  (ch_tick[c])
        );

        pwm_quad_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctl     (ch_ctl[c]),
            .prd_reg (ch_prd[c]),
            .cmp_reg (ch_cmp[c]),
            .tick    (ch_tick[c]),
            .run     (ch_run[c]),
            .pwm     (pwm_out[c])
        );
    end

endmodule

// File: rtl/pwm_quad_chk.sv
// Checker for pwm_quad: register readback, idle output and tick-only
// output changes. Attached to every pwm_quad instance by the bind below.
module pwm_quad_chk
    import pwm_quad_pkg::*;
(
    input logic                         clk,
    input logic                         rst_n,
    input logic                         bus_we,
    input logic [ADDR_W-1:0]            bus_addr,
    input logic [DATA_W-1:0]            bus_wdata,
    input logic [DATA_W-1:0]            bus_rdata,
    input logic [CH_NUM-1:0]            pwm_out,
    input logic [CH_NUM-1:0][CTL_W-1:0] ctl,
    input logic [CH_NUM-1:0]            tick
);

    // R2: a control word write reads back masked on the next cycle
    a_r2_ctrl_readback: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bus_we) && ($past(bus_addr) == ADDR_W'(ADDR_CTL))
         && (bus_addr == ADDR_W'(ADDR_CTL)))
        |-> (bus_rdata == ($past(bus_wdata) & CTL_MASK)));

    // R2: a prescaler word write reads back masked on the next cycle
    a_r2_pre_readback: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bus_we) && ($past(bus_addr) == ADDR_W'(ADDR_PRE))
         && (bus_addr == ADDR_W'(ADDR_PRE)))
        |-> (bus_rdata == ($past(bus_wdata) & PRE_MASK)));

    for (genvar c = 0; c < CH_NUM; c++) begin : g_ch
        // R9: a disabled channel drives low
        a_r9_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
            !ctl[c][CTL_EN] |-> !pwm_out[c]);

        // R3: with steady control, the output moves only after a tick
        a_r3_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl[c][CTL_EN] && $past(ctl[c][CTL_EN]) && $past(ctl[c][CTL_EN], 2)
             && $stable(ctl[c]) && !$past(tick[c]))
            |-> $stable(pwm_out[c]));
    end

endmodule

bind pwm_quad pwm_quad_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out),
    .ctl       (ch_ctl),
    .tick      (ch_tick)
);

// File: tb/test_pwm_quad.sv
// Scoreboard bench: the driver configures a channel and queues the expected
// high-cycle and rising-edge counts for a window; the monitor measures them.
module test_pwm_quad;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_we;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    int n_vec = 0;
    int n_bad = 0;
    bit mon_busy = 1'b0;

    typedef struct {
        int    ch;
        int    win;
        int    exp_hi;
        int    exp_rise;
        string tag;
    } item_t;

    item_t sb_q[$];
    item_t mon_it;

    always #4 clk = ~clk;   // 125 MHz

    pwm_quad i_pwm_quad (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    function automatic int div_of(input int code);
        case (code)
            0: return 2;
            1: return 4;
            2: return 8;
            3: return 16;
            default: return 1;
        endcase
    endfunction

    function automatic int ctl_off(input int ch);
        case (ch)
            0: return 0;
            1: return 8;
            2: return 12;
            default: return 16;
        endcase
    endfunction

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        bus_we    = 1'b1;
        bus_addr  = 4'(addr);
        bus_wdata = data;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd_chk(input int addr, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_we   = 1'b0;
        bus_addr = 4'(addr);
        #1;
        n_vec++;
        if (bus_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s read word %0d: got %h expected %h", tag, addr, bus_rdata, exp);
        end
    endtask

    task automatic push(input int ch, input int win, input int hi, input int rise, input string tag);
        item_t it;
        it.ch = ch; it.win = win; it.exp_hi = hi; it.exp_rise = rise; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic drain();
        @(negedge clk);
        wait (sb_q.size() == 0 && !mon_busy);
    endtask

    // Configure one channel from idle, enable it and queue the expected counts.
    task automatic run_case(input int ch, input int pre, input int code, input int prd,
                            input int cmp, input int ctl, input int k, input string tag);
        int ppr, lt, per, hi, rise;
        wr(2, 0);
        wr(0, 32'(pre));
        wr(1, 32'(code) << (4 * ch));
        wr(4 + ch, 32'(prd));
        wr(8 + ch, 32'(cmp));
        wr(2, 32'(ctl) << ctl_off(ch));
        repeat (3) @(negedge clk);
        ppr = (pre >> (8 * (ch / 2))) & 255;
        lt  = (ppr + 1) * div_of(code);
        per = (prd + 1) * lt;
        if ((ctl & 1) == 0)  hi = 0;
        else if (prd == 0)   hi = 0;
        else if (cmp >= prd) hi = per;
        else                 hi = (cmp + 1) * lt;
        if ((ctl & 1) != 0 && (ctl & 4) != 0) hi = per - hi;
        rise = (hi == 0 || hi == per) ? 0 : k;
        push(ch, k * per, k * hi, rise, tag);
        drain();
    endtask

    // Monitor: measure high cycles and rising edges over each queued window.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                int hi, rise;
                logic prev, cur;
                mon_it   = sb_q.pop_front();
                mon_busy = 1'b1;
                hi = 0; rise = 0;
                prev = pwm_out[mon_it.ch];
                for (int i = 0; i < mon_it.win; i++) begin
                    @(negedge clk);
                    cur = pwm_out[mon_it.ch];
                    if (cur) hi++;
                    if (cur && !prev) rise++;
                    prev = cur;
                end
                n_vec++;
                if (hi != mon_it.exp_hi || rise != mon_it.exp_rise) begin
                    n_bad++;
                    $display("FAIL %s ch%0d: got high=%0d rises=%0d expected high=%0d rises=%0d",
                             mon_it.tag, mon_it.ch, hi, rise, mon_it.exp_hi, mon_it.exp_rise);
                end
                mon_busy = 1'b0;
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (4) @(negedge clk);
        // R1: outputs low in reset
        n_vec++;
        if (pwm_out !== 4'b0) begin
            n_bad++;
            $display("FAIL R1 outputs in reset: got %b expected 0000", pwm_out);
        end
        rst_n = 1'b1;
        for (int a = 0; a < 12; a++) rd_chk(a, 32'h0, "R1");

        // R2: all-ones writes read back only the field bits
        wr(0, 32'hFFFF_FFFF); rd_chk(0, 32'h0000_FFFF, "R2");
        wr(1, 32'hFFFF_FFFF); rd_chk(1, 32'h0000_7777, "R2");
        wr(2, 32'hFFFF_FFFF); rd_chk(2, 32'h000F_FF0F, "R2");
        wr(2, 32'h0);
        wr(5, 32'hFFFF_FFFF); rd_chk(5, 32'h0000_FFFF, "R2");
        wr(11, 32'hFFFF_FFFF); rd_chk(11, 32'h0000_FFFF, "R2");
        wr(1, 32'h0000_4444); rd_chk(1, 32'h0000_4444, "R2");
        wr(2, 32'h0005_020E); rd_chk(2, 32'h0005_020E, "R2");
        wr(2, 32'h0);

        // R3 R5: ch0 prescale 1, divide by 2 -> 4-cycle ticks, period 20, high 8
        run_case(0, 32'h0001, 0, 4, 1, 9, 3, "R3 R5 basic");
        // R8: same settings inverted -> high 12 of 20
        run_case(0, 32'h0001, 0, 4, 1, 13, 3, "R8 invert");
        // R4: ch1 takes low byte (2), ch2/ch3 take high byte (5)
        run_case(1, 32'h0502, 1, 3, 0, 9, 3, "R4 pair low byte");
        run_case(2, 32'h0502, 4, 5, 2, 9, 3, "R4 pair high byte");
        run_case(3, 32'h0502, 2, 2, 1, 9, 2, "R4 R3 pair high byte div8");
        // R3: divide by 16 and an out-of-range code acting as 1
        run_case(3, 32'h0000, 3, 2, 0, 9, 3, "R3 code3");
        run_case(0, 32'h0000, 6, 7, 2, 9, 4, "R3 code6");
        // R6: compare equal to and above period -> constant high
        run_case(1, 32'h0000, 4, 5, 5, 9, 4, "R6 cmp eq prd");
        run_case(1, 32'h0000, 4, 10, 65535, 9, 4, "R6 cmp max");
        // R7: stopped channel, plain and inverted
        run_case(2, 32'h0000, 0, 0, 3, 9, 8, "R7 stopped");
        run_case(2, 32'h0000, 0, 0, 3, 13, 8, "R7 stopped inverted");
        // R9: invert and reload set but not enabled -> low
        run_case(3, 32'h0000, 0, 4, 1, 12, 3, "R9 disabled");
        // R3: largest prescaler with divide by 16 -> 4096-cycle ticks
        run_case(2, 32'hFF00, 3, 1, 0, 9, 2, "R3 max prescale");

        // R10: single-period mode, ch1: 2-cycle ticks, period 12, pulse 6
        wr(2, 0); wr(0, 0); wr(1, 0); wr(5, 5); wr(9, 2);
        wr(2, 32'h1 << ctl_off(1));
        push(1, 48, 6, 1, "R10 one pulse");
        drain();
        push(1, 48, 0, 0, "R10 silent after pulse");
        drain();
        wr(2, 0);
        wr(2, 32'h1 << ctl_off(1));
        push(1, 48, 6, 1, "R10 re-arm");
        drain();

        // R11: compare raised right after enable leaves the running pulse alone
        wr(2, 0);
        wr(2, 32'h1 << ctl_off(1));
        wr(9, 4);
        push(1, 48, 6, 1, "R11 deferred compare");
        drain();

        // R11: in auto-reload the new compare applies from the next period
        run_case(0, 32'h0001, 0, 4, 1, 9, 1, "R11 before update");
        wr(8, 3);
        repeat (44) @(negedge clk);
        push(0, 60, 48, 3, "R11 after update");
        drain();

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule